// File: doc/BRIEF.md
# Board System Control Register File

This block is a 4 KB window of control and identification registers for an FPGA board image. A simple 32-bit request bus reaches it. Software uses it to hold general configuration words, to light a row of LEDs, and to read back fixed identity values for the image. A status register for the board's clock DLLs reports the lock state of each DLL. It also reports one summary lock bit, and a writable mask chooses which DLLs that summary covers.

The identity word is a parameter. A 12-bit part number inside it picks which optional configuration registers exist, so one source serves several board images. An access to an offset that does not exist in the current image reads as zero and has no effect on any state. The same cycle's response carries an error flag. The serial configuration channel is not decoded here, so its offsets also report an error. Every request gets a response one cycle later.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, the general registers at 0x00, 0x04, 0x08, 0x14 and 0x18 read zero and `led_o` is zero. With all lock inputs high, the DLL register at 0x100 reads 0xFFFF0001.
- R2: A request sampled at a clock edge produces `rsp_valid` high after that same edge, for one cycle. A read returns its data in `rsp_rdata` in that cycle. At every other time, and for writes, `rsp_rdata` is zero.
- R3: The register at 0x00 is a full 32-bit read/write word. A write takes effect at the edge where it is sampled, so a read issued in the next cycle returns the new value.
- R4: The register at 0x04 is 32-bit read/write, and `led_o[i]` equals its bit i (active high) from the cycle after the write.
- R5: The part number is ID bits [15:4]. The registers at 0x08 and 0x14 exist only for part numbers 0x524 and 0x547.
- R6: The register at 0x18 exists only for part number 0x524.
- R7: Offset 0x0C reads zero without error. Offsets 0x10, 0xFF8 and 0xFFC read the parameters `CFG4_VAL`, `AID_VAL` and `ID_VAL`. A write to any of these four offsets is ignored and flags an error.
- R8: In the DLL register, only bits [31:24] (the lock mask) are writable. Bits [23:16] show `dll_lock_i` as sampled with the read. Bit 0 is 1 when every DLL whose mask bit is set is locked. Bits [15:1] read zero.
- R9: A read or write to an offset that does not exist returns zero data, changes no register, and sets `rsp_err` in the response cycle.
- R10: Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| dll_lock_i | input | 8 | Per-DLL lock inputs |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access hit a missing or non-writable offset |
| led_o | output | 8 | LED drive, from the register at 0x04 |

## Verification
A write to the DLL lock mask can land in the same cycle as a change on the lock inputs, and the summary bit has to reflect both. The bench rewrites the mask in the edge where the lock inputs move, with the newly masked DLLs locked and the others unlocked. It then reads the register and requires the new mask, the new lock field and a set summary bit. A second case changes the locks so that a masked DLL drops, and the bench requires the summary bit to clear.

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int          AW       = 12,
  parameter int          DW       = 32,
  parameter int          LED_W    = 8,
  parameter logic [31:0] CFG4_VAL = 32'h0000_0003,
  parameter logic [31:0] AID_VAL  = 32'h0220_0000,
  parameter logic [31:0] ID_VAL   = 32'h4105_5241
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [7:0]    dll_lock_i,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic [LED_W-1:0] led_o
);
  localparam int          WA_W  = AW - 2;
  localparam logic [11:0] PART  = ID_VAL[15:4];
  localparam bit          HAS_X = (PART == 12'h524) || (PART == 12'h547);
  localparam bit          HAS_D = (PART == 12'h524);

  localparam logic [WA_W-1:0] W_GEN0 = WA_W'(12'h000 >> 2);
  localparam logic [WA_W-1:0] W_LED  = WA_W'(12'h004 >> 2);
  localparam logic [WA_W-1:0] W_OPTA = WA_W'(12'h008 >> 2);
  localparam logic [WA_W-1:0] W_SW   = WA_W'(12'h00C >> 2);
  localparam logic [WA_W-1:0] W_FIX  = WA_W'(12'h010 >> 2);
  localparam logic [WA_W-1:0] W_OPTB = WA_W'(12'h014 >> 2);
  localparam logic [WA_W-1:0] W_OPTC = WA_W'(12'h018 >> 2);
  localparam logic [WA_W-1:0] W_DLL  = WA_W'(12'h100 >> 2);
  localparam logic [WA_W-1:0] W_AID  = WA_W'(12'hFF8 >> 2);
  localparam logic [WA_W-1:0] W_ID   = WA_W'(12'hFFC >> 2);

  logic [DW-1:0] gen0_q, led_q, opta_q, optb_q, optc_q;
  logic [7:0]    mask_q;
  logic [WA_W-1:0] wa;
  logic          rd_hit, wr_hit, dll_sum;
  logic [DW-1:0] rd_mux;

  assign wa      = req_addr[AW-1:2];
  assign dll_sum = &(dll_lock_i | ~mask_q);
  assign led_o   = led_q[LED_W-1:0];

  always_comb begin
    rd_hit = 1'b1;
    wr_hit = 1'b0;
    rd_mux = '0;
    case (wa)
      W_GEN0: begin rd_mux = gen0_q; wr_hit = 1'b1; end
      W_LED:  begin rd_mux = led_q;  wr_hit = 1'b1; end
      W_OPTA: begin rd_mux = opta_q; rd_hit = HAS_X; wr_hit = HAS_X; end
      W_SW:   rd_mux = '0;
      W_FIX:  rd_mux = CFG4_VAL;
      W_OPTB: begin rd_mux = optb_q; rd_hit = HAS_X; wr_hit = HAS_X; end
      W_OPTC: begin rd_mux = optc_q; rd_hit = HAS_D; wr_hit = HAS_D; end
      W_DLL:  begin rd_mux = {mask_q, dll_lock_i, 15'd0, dll_sum}; wr_hit = 1'b1; end
      W_AID:  rd_mux = AID_VAL;
      W_ID:   rd_mux = ID_VAL;
      default: rd_hit = 1'b0;
    endcase
    if (!rd_hit) rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen0_q <= '0;
      led_q  <= '0;
      opta_q <= '0;
      optb_q <= '0;
      optc_q <= '0;
      mask_q <= 8'hFF;
    end else if (req_valid && req_write && wr_hit) begin
      case (wa)
        W_GEN0: gen0_q <= req_wdata;
        W_LED:  led_q  <= req_wdata;
        W_OPTA: opta_q <= req_wdata;
        W_OPTB: optb_q <= req_wdata;
        W_OPTC: optc_q <= req_wdata;
        W_DLL:  mask_q <= req_wdata[31:24];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && (req_write ? !wr_hit : !rd_hit);
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int          AW     = 12,
  parameter int          DW     = 32,
  parameter int          LED_W  = 8,
  parameter logic [31:0] ID_VAL = 32'h4105_5241
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic [7:0]    dll_lock_i,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_err,
  input logic [LED_W-1:0] led_o
);
  logic rd_dll, rd_id, wr_led;
  assign rd_dll = req_valid && !req_write && (req_addr[AW-1:2] == (AW-2)'(12'h100 >> 2));
  assign rd_id  = req_valid && !req_write && (req_addr[AW-1:2] == (AW-2)'(12'hFFC >> 2));
  assign wr_led = req_valid &&  req_write && (req_addr[AW-1:2] == (AW-2)'(12'h004 >> 2));

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_idle_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_rdata == '0 && !rsp_err));
  assert_led_tracks_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_led |=> (led_o == $past(req_wdata[LED_W-1:0])));
  assert_dll_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dll |=> (rsp_rdata[23:16] == $past(dll_lock_i) && rsp_rdata[15:1] == '0 && !rsp_err));
  assert_id_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id |=> (rsp_rdata == ID_VAL));
  assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0 && rsp_valid));
endmodule

bind sysctl_regfile sysctl_regfile_chk #(.AW(AW), .DW(DW), .LED_W(LED_W), .ID_VAL(ID_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .dll_lock_i(dll_lock_i),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .led_o(led_o));

// File: tb/tb_sysctl_regfile.sv
module tb_sysctl_regfile;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CFG4 = 32'h0000_0003;
  localparam logic [31:0] AID  = 32'h0220_0000;
  localparam logic [31:0] ID_A = 32'h4105_5241;
  localparam logic [31:0] ID_B = 32'h4105_5111;
  localparam logic [31:0] ID_C = 32'h4105_5471;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  dll_lock = 8'hFF;
  logic        vld_a, vld_b, vld_c, err_a, err_b, err_c;
  logic [31:0] rd_a, rd_b, rd_c;
  logic [7:0]  led_a, led_b, led_c;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regfile #(.CFG4_VAL(CFG4), .AID_VAL(AID), .ID_VAL(ID_A)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .dll_lock_i(dll_lock), .rsp_valid(vld_a), .rsp_rdata(rd_a),
    .rsp_err(err_a), .led_o(led_a));
  sysctl_regfile #(.CFG4_VAL(CFG4), .AID_VAL(AID), .ID_VAL(ID_B)) dut_b (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .dll_lock_i(dll_lock), .rsp_valid(vld_b), .rsp_rdata(rd_b),
    .rsp_err(err_b), .led_o(led_b));
  sysctl_regfile #(.CFG4_VAL(CFG4), .AID_VAL(AID), .ID_VAL(ID_C)) dut_c (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .dll_lock_i(dll_lock), .rsp_valid(vld_c), .rsp_rdata(rd_c),
    .rsp_err(err_c), .led_o(led_c));

  // row: {write, addr, wdata, expected rdata, expected err}, checked on the part-0x524 instance
  localparam int NV = 26;
  localparam logic [77:0] VEC [NV] = '{
    {1'b0, 12'h000, 32'h0,          32'h0,          1'b0},  // R1
    {1'b1, 12'h000, 32'hDEADBEEF,   32'h0,          1'b0},  // R3
    {1'b0, 12'h000, 32'h0,          32'hDEADBEEF,   1'b0},  // R3
    {1'b1, 12'h004, 32'h000000A5,   32'h0,          1'b0},  // R4
    {1'b0, 12'h004, 32'h0,          32'h000000A5,   1'b0},  // R4
    {1'b1, 12'h008, 32'h12345678,   32'h0,          1'b0},  // R5
    {1'b0, 12'h008, 32'h0,          32'h12345678,   1'b0},  // R5
    {1'b1, 12'h014, 32'h017D7840,   32'h0,          1'b0},  // R5
    {1'b0, 12'h014, 32'h0,          32'h017D7840,   1'b0},  // R5
    {1'b1, 12'h018, 32'h00000003,   32'h0,          1'b0},  // R6
    {1'b0, 12'h018, 32'h0,          32'h00000003,   1'b0},  // R6
    {1'b0, 12'h00C, 32'h0,          32'h0,          1'b0},  // R7
    {1'b0, 12'h010, 32'h0,          CFG4,           1'b0},  // R7
    {1'b1, 12'h010, 32'hFFFFFFFF,   32'h0,          1'b1},  // R7
    {1'b0, 12'h010, 32'h0,          CFG4,           1'b0},  // R7
    {1'b0, 12'hFF8, 32'h0,          AID,            1'b0},  // R7
    {1'b1, 12'hFFC, 32'h0,          32'h0,          1'b1},  // R7
    {1'b0, 12'hFFC, 32'h0,          ID_A,           1'b0},  // R7
    {1'b0, 12'h020, 32'h0,          32'h0,          1'b1},  // R9
    {1'b1, 12'h020, 32'h55555555,   32'h0,          1'b1},  // R9
    {1'b0, 12'h0A8, 32'h0,          32'h0,          1'b1},  // R9
    {1'b0, 12'h003, 32'h0,          32'hDEADBEEF,   1'b0},  // R10
    {1'b1, 12'h006, 32'h0000005A,   32'h0,          1'b0},  // R10
    {1'b0, 12'h005, 32'h0,          32'h0000005A,   1'b0},  // R10
    {1'b1, 12'h100, 32'h0F00FFFF,   32'h0,          1'b0},  // R8
    {1'b0, 12'h100, 32'h0,          32'h0FFF0001,   1'b0}   // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 led", {24'd0, led_a}, 32'h0);
    chk("R2 idle valid", {31'd0, vld_a}, 32'h0);
    bus(1'b0, 12'h100, 32'h0);
    chk("R1 dll reset", rd_a, 32'hFFFF0001);
    bus(1'b0, 12'h018, 32'h0);
    chk("R1 reg18 reset", rd_a, 32'h0);
    chk("R2 valid", {31'd0, vld_a}, 32'h1);
    @(negedge clk);
    chk("R2 drop", {31'd0, vld_a}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][77], VEC[i][76:65], VEC[i][64:33]);
      chk($sformatf("table row %0d rdata", i), rd_a, VEC[i][32:1]);
      chk($sformatf("table row %0d err", i), {31'd0, err_a}, {31'd0, VEC[i][0]});
    end
    chk("R4 led after write", {24'd0, led_a}, 32'h0000005A);

    dll_lock = 8'hF0;
    bus(1'b0, 12'h100, 32'h0);
    chk("R8 masked unlocked", rd_a, 32'h0FF00000);
    dll_lock = 8'h0F;
    bus(1'b0, 12'h100, 32'h0);
    chk("R8 masked locked", rd_a, 32'h0F0F0001);
    @(negedge clk);
    dll_lock = 8'hF0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h100; req_wdata = 32'hF0000000;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    bus(1'b0, 12'h100, 32'h0);
    chk("R8 mask and lock same cycle", rd_a, 32'hF0F00001);
    dll_lock = 8'h70;
    bus(1'b0, 12'h100, 32'h0);
    chk("R8 summary clears", rd_a, 32'hF0700000);

    bus(1'b0, 12'h008, 32'h0);
    chk("R5 part511 reg08 data", rd_b, 32'h0);
    chk("R5 part511 reg08 err", {31'd0, err_b}, 32'h1);
    chk("R5 part547 reg08 data", rd_c, 32'h12345678);
    bus(1'b0, 12'h014, 32'h0);
    chk("R5 part511 reg14 data", rd_b, 32'h0);
    chk("R5 part547 reg14 data", rd_c, 32'h017D7840);
    bus(1'b1, 12'h018, 32'h7);
    chk("R6 part547 write err", {31'd0, err_c}, 32'h1);
    chk("R6 part524 write ok", {31'd0, err_a}, 32'h0);
    bus(1'b0, 12'h018, 32'h0);
    chk("R6 part547 read", rd_c, 32'h0);
    chk("R6 part547 read err", {31'd0, err_c}, 32'h1);
    chk("R6 part511 read err", {31'd0, err_b}, 32'h1);
    chk("R6 part524 read", rd_a, 32'h7);
    bus(1'b0, 12'hFFC, 32'h0);
    chk("R7 id part511", rd_b, ID_B);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    dll_lock = 8'hFF;
    chk("R1 led after reset", {24'd0, led_a}, 32'h0);
    bus(1'b0, 12'h000, 32'h0);
    chk("R1 reg00 after reset", rd_a, 32'h0);
    bus(1'b0, 12'h100, 32'h0);
    chk("R1 dll after reset", rd_a, 32'hFFFF0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule